// File: doc/BRIEF.md
# Read strobe delay window calibrator

This block runs the read strobe delay training of a memory controller for one or two byte lanes. Each lane owns one byte of a delay word: a coarse step count in the upper nibble and a fine step count in the lower nibble. For every lane the block walks the coarse and then the fine setting upward until a trial fails, which gives the top edge of the passing window. It then walks coarse and fine downward, stopping at limits derived from a DLL code, which gives the bottom edge. The centre of that window is stored as the lane's byte. When every lane is done, the block commits the finished word to its delay register output.

Each trial is run by an external pattern tester. The block presents a candidate delay word and a bias code, pulses a start strobe, and waits for the tester's done strobe before it reads the error flag. For the whole run it forces auto self-refresh off and clears the strobe gating-window enables of the lanes under training. Once the run ends it hands both back to their configured values.

Top module: `strobe_window_cal`

## Requirements
- R1: After reset, `delay_word_o` holds coarse 7 and fine 4 in every lane, which is byte 0x74 (lane i at bits [8i+7:8i], coarse in [7:4], fine in [3:0]). At the same time `busy_o`, `done_o` and `trial_go_o` are low, and `sref_en_o` and `gate_en_o` follow `sref_cfg_i` and `gate_cfg_i`.
- R2: Each trial raises `trial_go_o` for exactly one cycle. `trial_word_o` and `trial_bias_o` hold still until the tester returns `trial_done_i`, and `trial_err_i` is sampled only with `trial_done_i`.
- R3: The coarse maximum search starts at 7 and counts up to 15, with the lane's fine field at 0xF. On the first failure at value v the result is max(v-1, 7). If no trial fails, the result is 15.
- R4: The fine maximum search starts at 0, with coarse at the coarse maximum, and follows the R3 rule with start 0 and top 15. A result of 0 lowers the coarse maximum by one and sets the fine maximum to 15. Any other result r gives a fine maximum of r-1.
- R5: The coarse minimum search starts at 6 and counts down to the coarse limit, with the lane's fine field at 0. On the first failure at v the result is min(v+1, 6). If no trial fails, the result is the limit. When the limit is above 6, no trial is run and the limit is taken as the result.
- R6: The fine minimum search starts at 15, with coarse at the coarse minimum, and counts down to the fine limit using the R5 rule. A result of 16 would raise the coarse minimum and set the fine minimum to 0. Otherwise the result is the fine minimum.
- R7: The limits come from the 8-bit `dll_code_i`, captured at start. The coarse limit is 8 minus bits [7:4] when that nibble is at most 8, and 0 otherwise. The fine limit is computed the same way from bits [3:0].
- R8: The lane's centre coarse is (cmax+cmin)>>1. The centre fine is 4*((cmax+cmin) mod 2) + ((fmax+fmin)>>1). When the centre fine is 16 or more, the coarse goes up by one and the fine goes down by 8.
- R9: `trial_bias_o` is 3 during both maximum searches and 1 during both minimum searches.
- R10: With `wide16_i` high at start, lanes 0 and then 1 are trained. With it low, only lane 0 is trained and lane 1 keeps 0x74. In a candidate word, earlier lanes hold their centres and later lanes hold 0x74.
- R11: While `busy_o` is high, `sref_en_o` is 0. During the same time `gate_en_o` is the `gate_cfg_i` value captured at start, with bit 0 cleared and bit 1 cleared only for a 16-bit run. While idle, both outputs follow their configuration inputs again.
- R12: `done_o` pulses for one cycle in the same cycle that `busy_o` falls and the new `delay_word_o` appears. A `cal_start_i` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | Begin a calibration run (sampled while idle) |
| wide16_i | input | 1 | 1 = 16-bit bus (two lanes), 0 = 8-bit bus |
| dll_code_i | input | 8 | DLL delay reading used for the lower limits |
| sref_cfg_i | input | 1 | Configured auto self-refresh enable |
| gate_cfg_i | input | 2 | Configured gating-window enables per lane |
| sref_en_o | output | 1 | Effective auto self-refresh enable |
| gate_en_o | output | 2 | Effective gating-window enables per lane |
| trial_go_o | output | 1 | One-cycle start strobe to the tester |
| trial_word_o | output | 16 | Candidate delay word for the trial |
| trial_bias_o | output | 2 | Pattern bias code for the trial |
| trial_done_i | input | 1 | Tester finished the trial |
| trial_err_i | input | 1 | Trial failed (valid with trial_done_i) |
| delay_word_o | output | 16 | Committed delay register value |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The bench sweeps passing windows whose edges sit below the first coarse probe, above the last one and in between. This covers the case where the fine maximum search fails at once and the coarse maximum must drop, which a design that skipped the decrement would centre one coarse step too high. DLL codes put the coarse limit above the coarse minimum start, so that no downward coarse trial is run; a design that still probed there would issue an extra trial that the bench's trial-by-trial comparison reports. Odd coarse sums with large fine sums force the centre fine to 16 or more, where a missing carry leaves a wrapped fine value. A DLL code changed mid-run and a stray start pulse check that the limits and the run are latched at start.

// File: rtl/swc_pkg.sv
package swc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } swc_state_e;

   typedef enum logic [1:0] {
      PH_CMAX,
      PH_FMAX,
      PH_CMIN,
      PH_FMIN
   } swc_phase_e;

endpackage

// File: rtl/swc_limits.sv
module swc_limits #(
   parameter int FW = 4
) (
   input  logic [2*FW-1:0] dll_i,
   output logic [FW-1:0]   clim_o,
   output logic [FW-1:0]   flim_o
);
   localparam logic [FW-1:0] MID = FW'(1 << (FW-1));

   logic [FW-1:0] lim [2];

   for (genvar g = 0; g < 2; g++) begin : g_nib
      logic [FW-1:0] nib;
      assign nib    = dll_i[g*FW +: FW];
      assign lim[g] = (nib <= MID) ? (MID - nib) : '0;
   end

   assign flim_o = lim[0];
   assign clim_o = lim[1];
endmodule

// File: rtl/swc_step.sv
module swc_step #(
   parameter int FW = 4
) (
   input  logic          up_i,
   input  logic [FW-1:0] cur_i,
   input  logic [FW-1:0] start_i,
   input  logic [FW-1:0] bound_i,
   input  logic          fail_i,
   output logic          fin_o,
   output logic [FW:0]   res_o,
   output logic [FW-1:0] nxt_o
);
   always_comb begin
      fin_o = 1'b0;
      nxt_o = cur_i;
      res_o = {1'b0, cur_i};
      if (fail_i) begin
         fin_o = 1'b1;
         if (cur_i == start_i)
            res_o = {1'b0, start_i};
         else if (up_i)
            res_o = {1'b0, cur_i} - (FW+1)'(1);
         else
            res_o = {1'b0, cur_i} + (FW+1)'(1);
      end else if (cur_i == bound_i) begin
         fin_o = 1'b1;
         res_o = {1'b0, bound_i};
      end else begin
         nxt_o = up_i ? (cur_i + FW'(1)) : (cur_i - FW'(1));
      end
   end
endmodule

// File: rtl/swc_centre.sv
module swc_centre #(
   parameter int FW = 4
) (
   input  logic [FW-1:0]   cmax_i,
   input  logic [FW-1:0]   cmin_i,
   input  logic [FW-1:0]   fmax_i,
   input  logic [FW-1:0]   fmin_i,
   output logic [2*FW-1:0] byte_o
);
   localparam logic [FW:0] QTR  = (FW+1)'(1 << (FW-2));
   localparam logic [FW:0] HALF = (FW+1)'(1 << (FW-1));
   localparam logic [FW:0] FULL = (FW+1)'(1 << FW);

   logic [FW:0]   csum;
   logic [FW-1:0] cc;
   logic [FW:0]   fc;

   always_comb begin
      csum = {1'b0, cmax_i} + {1'b0, cmin_i};
      cc   = csum[FW:1];
      fc   = (csum[0] ? QTR : '0) + (({1'b0, fmax_i} + {1'b0, fmin_i}) >> 1);
      if (fc >= FULL) begin
         cc = cc + FW'(1);
         fc = fc - HALF;
      end
      byte_o = {cc, fc[FW-1:0]};
   end
endmodule

// File: rtl/strobe_window_cal.sv
module strobe_window_cal
   import swc_pkg::*;
#(
   parameter int         LANES   = 2,
   parameter int         FW      = 4,
   parameter logic [1:0] BIAS_HI = 2'd3,
   parameter logic [1:0] BIAS_LO = 2'd1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cal_start_i,
   input  logic                      wide16_i,
   input  logic [2*FW-1:0]           dll_code_i,
   input  logic                      sref_cfg_i,
   input  logic [LANES-1:0]          gate_cfg_i,
   output logic                      sref_en_o,
   output logic [LANES-1:0]          gate_en_o,
   output logic                      trial_go_o,
   output logic [LANES*2*FW-1:0]     trial_word_o,
   output logic [1:0]                trial_bias_o,
   input  logic                      trial_done_i,
   input  logic                      trial_err_i,
   output logic [LANES*2*FW-1:0]     delay_word_o,
   output logic                      busy_o,
   output logic                      done_o
);
   localparam int BW = 2*FW;
   localparam int W  = LANES*BW;
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

   localparam logic [FW-1:0] F_ONES     = '1;
   localparam logic [FW-1:0] CMAX_START = FW'((1 << (FW-1)) - 1);
   localparam logic [FW-1:0] CMIN_START = CMAX_START - FW'(1);
   localparam logic [FW-1:0] FMAX_START = '0;
   localparam logic [FW-1:0] FMIN_START = F_ONES;
   localparam logic [FW-1:0] DEF_FINE   = FW'(1 << (FW-2));
   localparam logic [BW-1:0] DEF_BYTE   = {CMAX_START, DEF_FINE};
   localparam logic [W-1:0]  DEF_WORD   = {LANES{DEF_BYTE}};
   localparam logic [FW:0]   FMIN_WRAP  = {1'b0, FMIN_START} + (FW+1)'(1);

   if (LANES < 1 || LANES > 2) begin : g_bad_lanes
      $error("strobe_window_cal: LANES must be 1 or 2");
   end
   if (FW < 3) begin : g_bad_fw
      $error("strobe_window_cal: FW must be at least 3");
   end

   swc_state_e      st;
   swc_phase_e      ph;
   logic [LW-1:0]   lane;
   logic [FW-1:0]   val, cmax_q, cmin_q, fmax_q;
   logic [FW-1:0]   clim_q, flim_q, clim_w, flim_w;
   logic [W-1:0]    acc, dly;
   logic            wide_q, done_q;
   logic [LANES-1:0] gate_sv, gmask;
   logic            lane_last;

   logic            up_w;
   logic [FW-1:0]   start_w, bound_w;
   logic            stp_fin;
   logic [FW:0]     stp_res;
   logic [FW-1:0]   stp_nxt;
   logic [FW-1:0]   cmin_w, fmin_w;
   logic [BW-1:0]   ctr_byte, tbyte;

   swc_limits #(.FW(FW)) i_limits (
      .dll_i  (dll_code_i),
      .clim_o (clim_w),
      .flim_o (flim_w)
   );

   always_comb begin
      unique case (ph)
         PH_CMAX: begin up_w = 1'b1; start_w = CMAX_START; bound_w = F_ONES; tbyte = {val, F_ONES}; end
         PH_FMAX: begin up_w = 1'b1; start_w = FMAX_START; bound_w = F_ONES; tbyte = {cmax_q, val}; end
         PH_CMIN: begin up_w = 1'b0; start_w = CMIN_START; bound_w = clim_q; tbyte = {val, FW'(0)}; end
         PH_FMIN: begin up_w = 1'b0; start_w = FMIN_START; bound_w = flim_q; tbyte = {cmin_q, val}; end
      endcase
   end

   swc_step #(.FW(FW)) i_step (
      .up_i    (up_w),
      .cur_i   (val),
      .start_i (start_w),
      .bound_i (bound_w),
      .fail_i  (trial_err_i),
      .fin_o   (stp_fin),
      .res_o   (stp_res),
      .nxt_o   (stp_nxt)
   );

   always_comb begin
      if (stp_res == FMIN_WRAP) begin
         cmin_w = cmin_q + FW'(1);
         fmin_w = '0;
      end else begin
         cmin_w = cmin_q;
         fmin_w = stp_res[FW-1:0];
      end
   end

   swc_centre #(.FW(FW)) i_centre (
      .cmax_i (cmax_q),
      .cmin_i (cmin_w),
      .fmax_i (fmax_q),
      .fmin_i (fmin_w),
      .byte_o (ctr_byte)
   );

   if (LANES == 2) begin : g_dual
      assign gmask     = {wide_q, 1'b1};
      assign lane_last = (lane == LW'(wide_q));
   end else begin : g_single
      assign gmask     = '1;
      assign lane_last = 1'b1;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_word
      assign trial_word_o[g*BW +: BW] = (lane == LW'(g)) ? tbyte : acc[g*BW +: BW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_CMAX;
         lane    <= '0;
         val     <= '0;
         cmax_q  <= '0;
         cmin_q  <= '0;
         fmax_q  <= '0;
         clim_q  <= '0;
         flim_q  <= '0;
         acc     <= DEF_WORD;
         dly     <= DEF_WORD;
         wide_q  <= 1'b0;
         gate_sv <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (cal_start_i) begin
                  wide_q  <= wide16_i;
                  clim_q  <= clim_w;
                  flim_q  <= flim_w;
                  gate_sv <= gate_cfg_i;
                  acc     <= DEF_WORD;
                  lane    <= '0;
                  ph      <= PH_CMAX;
                  val     <= CMAX_START;
                  st      <= ST_ISSUE;
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (trial_done_i) begin
                  st <= ST_ISSUE;
                  if (!stp_fin) begin
                     val <= stp_nxt;
                  end else begin
                     unique case (ph)
                        PH_CMAX: begin
                           cmax_q <= stp_res[FW-1:0];
                           ph     <= PH_FMAX;
                           val    <= FMAX_START;
                        end
                        PH_FMAX: begin
                           if (stp_res == '0) begin
                              cmax_q <= cmax_q - FW'(1);
                              fmax_q <= F_ONES;
                           end else begin
                              fmax_q <= stp_res[FW-1:0] - FW'(1);
                           end
                           if (clim_q > CMIN_START) begin
                              cmin_q <= clim_q;
                              ph     <= PH_FMIN;
                              val    <= FMIN_START;
                           end else begin
                              ph     <= PH_CMIN;
                              val    <= CMIN_START;
                           end
                        end
                        PH_CMIN: begin
                           cmin_q <= stp_res[FW-1:0];
                           ph     <= PH_FMIN;
                           val    <= FMIN_START;
                        end
                        PH_FMIN: begin
                           acc[int'(lane)*BW +: BW] <= ctr_byte;
                           if (lane_last) begin
                              st <= ST_DONE;
                           end else begin
                              lane <= lane + LW'(1);
                              ph   <= PH_CMAX;
                              val  <= CMAX_START;
                           end
                        end
                     endcase
                  end
               end
            end
            ST_DONE: begin
               dly    <= acc;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o       = (st != ST_IDLE);
   assign done_o       = done_q;
   assign delay_word_o = dly;
   assign trial_go_o   = (st == ST_ISSUE);
   assign trial_bias_o = (ph == PH_CMAX || ph == PH_FMAX) ? BIAS_HI : BIAS_LO;
   assign sref_en_o    = sref_cfg_i & ~busy_o;
   assign gate_en_o    = busy_o ? (gate_sv & ~gmask) : gate_cfg_i;
endmodule

// File: rtl/strobe_window_cal_chk.sv
module strobe_window_cal_chk #(
   parameter int LANES = 2,
   parameter int W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [W-1:0]     word,
   input logic [1:0]       bias,
   input logic             busy,
   input logic             done,
   input logic             sref,
   input logic [LANES-1:0] gate
);
   // R2
   go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go);
   // R2
   go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> ($stable(word) && $stable(bias)));
   // R1
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) go |-> busy);
   // R9
   bias_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (bias == 2'd3 || bias == 2'd1));
   // R11
   sref_off_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sref);
   // R11
   gate_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !gate[0]);
   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
   // R12
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

bind strobe_window_cal strobe_window_cal_chk #(.LANES(LANES), .W(W)) i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .go    (trial_go_o),
   .word  (trial_word_o),
   .bias  (trial_bias_o),
   .busy  (busy_o),
   .done  (done_o),
   .sref  (sref_en_o),
   .gate  (gate_en_o)
);

// File: tb/test_strobe_window_cal.sv
module test_strobe_window_cal;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cal_start_i = 1'b0;
   logic        wide16_i = 1'b0;
   logic [7:0]  dll_code_i = 8'h00;
   logic        sref_cfg_i = 1'b1;
   logic [1:0]  gate_cfg_i = 2'b11;
   logic        sref_en_o;
   logic [1:0]  gate_en_o;
   logic        trial_go_o;
   logic [15:0] trial_word_o;
   logic [1:0]  trial_bias_o;
   logic        trial_done_i = 1'b0;
   logic        trial_err_i = 1'b0;
   logic [15:0] delay_word_o;
   logic        busy_o;
   logic        done_o;

   strobe_window_cal i_strobe_window_cal (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0, nfail = 0;
   int lo [2], hi [2];
   logic [15:0] exp_word [256];
   logic [1:0]  exp_bias [256];
   int exp_n;
   logic [15:0] exp_final;
   int tidx, mism, stab_bad, lat = 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   function automatic bit fails(input logic [15:0] w);
      for (int l = 0; l < 2; l++) begin
         int d;
         d = int'(w[8*l+4 +: 4]) * 8 + int'(w[8*l +: 4]);
         if (d < lo[l] || d > hi[l]) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic push(input logic [15:0] w, input logic [1:0] b);
      exp_word[exp_n] = w;
      exp_bias[exp_n] = b;
      exp_n++;
   endtask

   // Reference sweep built from R3..R10
   task automatic build_expected(input bit wide, input logic [7:0] dll);
      int clim, flim, cmax, fmax, cmin, fmin, r, s, cc, fc;
      logic [15:0] acc, base, w;
      exp_n = 0;
      acc = 16'h7474;
      clim = (dll[7:4] <= 8) ? 8 - int'(dll[7:4]) : 0;   // R7
      flim = (dll[3:0] <= 8) ? 8 - int'(dll[3:0]) : 0;
      for (int l = 0; l < (wide ? 2 : 1); l++) begin
         base = acc & ~(16'h00FF << (8*l));
         cmax = 15;                                       // R3
         for (int v = 7; v <= 15; v++) begin
            w = base | (16'(v*16 + 15) << (8*l));
            push(w, 2'd3);
            if (fails(w)) begin cmax = (v - 1 < 7) ? 7 : v - 1; break; end
         end
         r = 15;                                          // R4
         for (int v = 0; v <= 15; v++) begin
            w = base | (16'(cmax*16 + v) << (8*l));
            push(w, 2'd3);
            if (fails(w)) begin r = (v - 1 < 0) ? 0 : v - 1; break; end
         end
         if (r == 0) begin cmax = cmax - 1; fmax = 15; end
         else fmax = r - 1;
         cmin = clim;                                     // R5
         for (int v = 6; v >= clim; v--) begin
            w = base | (16'(v*16) << (8*l));
            push(w, 2'd1);
            if (fails(w)) begin cmin = (v + 1 > 6) ? 6 : v + 1; break; end
         end
         r = flim;                                        // R6
         for (int v = 15; v >= flim; v--) begin
            w = base | (16'(cmin*16 + v) << (8*l));
            push(w, 2'd1);
            if (fails(w)) begin r = (v + 1 > 15) ? 15 : v + 1; break; end
         end
         if (r == 16) begin cmin = cmin + 1; fmin = 0; end
         else fmin = r;
         s  = cmax + cmin;                                // R8
         cc = s / 2;
         fc = (s % 2) * 4 + (fmax + fmin) / 2;
         if (fc >= 16) begin cc = cc + 1; fc = fc - 8; end
         acc = base | (16'((cc % 16) * 16 + (fc % 16)) << (8*l));
      end
      exp_final = acc;
   endtask

   // Pattern tester model
   initial begin
      logic [15:0] w;
      logic [1:0]  b;
      forever begin
         @(negedge clk);
         if (trial_done_i) begin trial_done_i = 1'b0; trial_err_i = 1'b0; end
         if (trial_go_o) begin
            w = trial_word_o;
            b = trial_bias_o;
            if (tidx >= exp_n || w !== exp_word[tidx] || b !== exp_bias[tidx]) mism++;
            tidx++;
            repeat (lat) @(negedge clk);
            if (trial_word_o !== w || trial_bias_o !== b) stab_bad++;
            trial_done_i = 1'b1;
            trial_err_i  = fails(w);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      nchk++; nfail++;
      $display("FAIL R12 watchdog expired act=%0d exp=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   task automatic run(input bit wide, input logic [7:0] dll, input int l0lo, input int l0hi,
                      input int l1lo, input int l1hi, input logic [1:0] gcfg, input logic scfg);
      int cyc, dcnt, viol;
      logic [15:0] fw;
      logic [1:0]  gsave, gexp;
      bit busy_at_done, restore_ok;
      lo[0] = l0lo; hi[0] = l0hi; lo[1] = l1lo; hi[1] = l1hi;
      build_expected(wide, dll);
      tidx = 0; mism = 0; stab_bad = 0; dcnt = 0; viol = 0;
      busy_at_done = 1'b0; restore_ok = 1'b0; fw = '0;
      gate_cfg_i = gcfg; sref_cfg_i = scfg;
      gsave = gcfg;
      gexp  = gsave & ~{wide, 1'b1};
      @(negedge clk);
      wide16_i = wide; dll_code_i = dll; cal_start_i = 1'b1;
      @(negedge clk);
      cal_start_i = 1'b0;
      cyc = 0;
      while (cyc < 30000 && (dcnt == 0 || cyc < 0)) begin
         if (cyc == 5) begin cal_start_i = 1'b1; wide16_i = ~wide; end   // R12 ignored
         if (cyc == 6) begin cal_start_i = 1'b0; dll_code_i = ~dll; gate_cfg_i = ~gcfg; end
         if (busy_o && (sref_en_o !== 1'b0 || gate_en_o !== gexp)) viol++;
         if (done_o) begin
            dcnt++;
            fw = delay_word_o;
            busy_at_done = busy_o;
            restore_ok = (sref_en_o === sref_cfg_i) && (gate_en_o === gate_cfg_i);
         end
         if (dcnt == 0) begin @(negedge clk); cyc++; end
      end
      repeat (4) begin
         @(negedge clk);
         if (done_o) dcnt++;
      end
      chk(tidx == exp_n, "R10 trial count", tidx, exp_n);
      chk(mism == 0, "R3 R4 R5 R6 R7 R9 R10 trial word/bias sequence mismatches", mism, 0);
      chk(stab_bad == 0, "R2 trial word held until done", stab_bad, 0);
      chk(fw == exp_final, "R8 committed centre word", fw, exp_final);
      chk(dcnt == 1 && !busy_at_done, "R12 single done pulse with busy low", dcnt, 1);
      chk(viol == 0 && restore_ok, "R11 self-refresh/gating during and after run", viol, 0);
   endtask

   int plo [8] = '{0, 30, 45, 50, 60, 20, 70, 0};
   int phi [8] = '{127, 50, 70, 90, 60, 100, 127, 55};
   logic [7:0] dl [6] = '{8'h00, 8'h88, 8'h35, 8'hF9, 8'h2C, 8'h91};

   initial begin
      tidx = 0; exp_n = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(delay_word_o == 16'h7474, "R1 reset delay word", delay_word_o, 16'h7474);
      chk(!busy_o && !done_o && !trial_go_o, "R1 reset flags", {busy_o, done_o, trial_go_o}, 0);
      chk(sref_en_o == sref_cfg_i && gate_en_o == gate_cfg_i, "R1 reset pass-through",
          {sref_en_o, gate_en_o}, {sref_cfg_i, gate_cfg_i});
      rst_n = 1'b1;
      @(negedge clk);
      chk(delay_word_o == 16'h7474 && !busy_o, "R1 idle after reset", delay_word_o, 16'h7474);
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            lat = 1 + ((i + j) % 3);
            run(1'b1, dl[(i + j) % 6], plo[i], phi[i], plo[j], phi[j], 2'(i + j), 1'(j));
         end
      end
      for (int i = 0; i < 8; i++) begin
         for (int k = 0; k < 6; k++) begin
            lat = 1 + (k % 3);
            run(1'b0, dl[k], plo[i], phi[i], 0, 127, 2'(k), 1'(i));
         end
      end
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule